// File: doc/BRIEF.md
# MMIO Test Window with Read-Back Scratch

This block is a small memory-mapped test window for bring-up and self-test software. It sits behind a single-beat request/response bus: each request carries an address, a size code, a write flag and 64 bits of write data. Exactly one clock later the block returns a response strobe and 64 bits of read data, with byte lane 0 holding the lowest-addressed byte.

Two regions are decoded. The first is a 64-byte scratch area. Software may write it at 1, 2, 4 or 8 bytes and read the same bytes back. It is used to prove that stores, loads and byte-lane steering work end to end. The second is an 8-byte probe register that ignores writes and returns a fixed 32-bit signature, replicated to fill 8 bytes. Reads of the probe that start at an odd offset inside it return a shifted slice of the replicated signature, padded with 0xFF past its end. A read that decodes to neither region returns all ones.

The signature value and the base addresses of both regions are parameters. The scratch base must be a multiple of the scratch size. The probe region must lie below the scratch region and must not overlap it.

Top module: `mmio_test_window`

## Requirements
- R1: After reset `rspValid` is 0 and every scratch byte reads as zero.
- R2: A request with `reqValid` high produces `rspValid` high on the next clock. No response appears in the cycle after a clock with no request.
- R3: The size code `reqSize` is 0, 1, 2 or 3, for 1, 2, 4 or 8 bytes. A scratch write stores that many bytes of `reqWdata` in little-endian order: byte i of the access comes from bits [8i+7:8i]. A read returns those bytes in the same lanes, and lanes at or above the size read as zero.
- R4: The scratch byte offset is the low 6 bits of the access address minus the scratch base. A write changes only the bytes it covers.
- R5: A scratch access is taken only when the whole access, from its start to its start plus its size, lies inside the 64-byte area. A write that crosses the end changes nothing. A read that crosses the end returns all ones in all 64 bits.
- R6: A write to any of the 8 probe bytes, at any size, changes no scratch byte.
- R7: A probe read at offset 0 returns the low 1, 2, 4 or 8 bytes of the signature replicated twice, so an 8-byte read gives the signature in bits [31:0] and again in bits [63:32].
- R8: A probe read at offset k, where k is 1 to 7, returns in lane i, for i below the size, byte k+i of the replicated signature when k+i is below 8, and 0xFF otherwise. Lanes at or above the size read as zero.
- R9: A read that hits neither region returns all ones in all 64 bits.
- R10: A write response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqWdata | input | 64 | Write data, byte i of the access in lane i |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 64 | Read data, byte i of the access in lane i |

## Verification
The bench targets the probe slices at offsets 3 and 7, where a design that rotates the signature instead of padding would return signature bytes where 0xFF belongs. It also targets scratch accesses that end exactly at byte 64 or one byte past it. An off-by-one bounds check there would either refuse a legal access or wrap onto byte 0 and corrupt it. A narrow write into a filled doubleword is read back at full width, which catches lane steering that clobbers neighbouring bytes. Writes to the probe are followed by scratch reads, which catch a decoder that lets such a write reach the scratch.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  localparam int LANES    = 8;
  localparam int NOP_SPAN = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic ack;
    logic rbWrite;
    logic rbRead;
    logic nopRead;
    logic missRead;
  } strobe_t;
endpackage

// File: rtl/mtw_ctrl.sv
module mtw_ctrl
  import mtw_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] NOP_BASE = 16'h0010,
  parameter logic [ADDR_W-1:0] RB_BASE  = 16'h0100,
  parameter int              RB_BYTES = 64,
  localparam int             OFF_W    = $clog2(RB_BYTES)
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output strobe_t           strobes,
  output logic [OFF_W-1:0]  byteOff,
  output logic [2:0]        nopIdx,
  output logic [3:0]        nBytes
);
  localparam int EXT_W = ADDR_W + 2;

  logic [EXT_W-1:0] addrExt;
  logic [EXT_W-1:0] nopDelta;
  logic [EXT_W-1:0] rbDelta;
  logic [EXT_W-1:0] rbEnd;
  logic             inNop;
  logic             rbFits;
  size_e            sizeCode;

  always_comb begin
    sizeCode = size_e'(reqSize);
    case (sizeCode)
      SZ_BYTE:  nBytes = 4'd1;
      SZ_HALF:  nBytes = 4'd2;
      SZ_WORD:  nBytes = 4'd4;
      default:  nBytes = 4'd8;
    endcase

    addrExt  = EXT_W'(reqAddr);
    nopDelta = addrExt - EXT_W'(NOP_BASE);
    rbDelta  = addrExt - EXT_W'(RB_BASE);
    rbEnd    = rbDelta + EXT_W'(nBytes);

    inNop  = (reqAddr >= NOP_BASE) && (nopDelta < EXT_W'(NOP_SPAN));
    rbFits = (reqAddr >= RB_BASE) && (rbEnd <= EXT_W'(RB_BYTES));

    byteOff = rbDelta[OFF_W-1:0];
    nopIdx  = nopDelta[2:0];

    strobes.ack      = reqValid;
    strobes.rbWrite  = reqValid && reqWrite && rbFits && !inNop;
    strobes.rbRead   = reqValid && !reqWrite && rbFits && !inNop;
    strobes.nopRead  = reqValid && !reqWrite && inNop;
    strobes.missRead = reqValid && !reqWrite && !inNop && !rbFits;
  end
endmodule

// File: rtl/mtw_datapath.sv
module mtw_datapath
  import mtw_pkg::*;
#(
  parameter int          RB_BYTES  = 64,
  parameter logic [31:0] SIGNATURE = 32'h5A17_C3E9,
  localparam int         OFF_W     = $clog2(RB_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [OFF_W-1:0] byteOff,
  input  logic [2:0]       nopIdx,
  input  logic [3:0]       nBytes,
  input  logic [63:0]      wdata,
  output logic             rspValid,
  output logic [63:0]      rspRdata
);
  localparam logic [63:0] SIG_REP = {SIGNATURE, SIGNATURE};

  logic [7:0]  scratch [RB_BYTES];
  logic [7:0]  laneData [LANES];
  logic [63:0] rdNext;

  // scratch store, little-endian lane steering
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < RB_BYTES; j++) scratch[j] <= '0;
    end else if (strobes.rbWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (4'(i) < nBytes)
          scratch[OFF_W'(byteOff + OFF_W'(i))] <= wdata[8*i +: 8];
      end
    end
  end

  // one read mux per lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [OFF_W-1:0] laneIdx;
    logic [3:0]       nopPos;
    logic [7:0]       nopByte;
    logic             laneOn;

    always_comb begin
      laneIdx = OFF_W'(byteOff + OFF_W'(g));
      nopPos  = {1'b0, nopIdx} + 4'(g);
      nopByte = nopPos[3] ? 8'hFF : SIG_REP[{nopPos[2:0], 3'b000} +: 8];
      laneOn  = 4'(g) < nBytes;
      if (!laneOn)               laneData[g] = 8'h00;
      else if (strobes.nopRead)  laneData[g] = nopByte;
      else if (strobes.rbRead)   laneData[g] = scratch[laneIdx];
      else                       laneData[g] = 8'h00;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) rdNext[8*i +: 8] = laneData[i];
    if (strobes.missRead) rdNext = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobes.ack;
      rspRdata <= strobes.ack ? rdNext : '0;
    end
  end
endmodule

// File: rtl/mmio_test_window.sv
module mmio_test_window
  import mtw_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] NOP_BASE  = 16'h0010,
  parameter logic [ADDR_W-1:0] RB_BASE   = 16'h0100,
  parameter int                RB_BYTES  = 64,
  parameter logic [31:0]       SIGNATURE = 32'h5A17_C3E9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic [63:0]       rspRdata
);
  localparam int OFF_W = $clog2(RB_BYTES);

  strobe_t          strobes;
  logic [OFF_W-1:0] byteOff;
  logic [2:0]       nopIdx;
  logic [3:0]       nBytes;

  mtw_ctrl #(
    .ADDR_W(ADDR_W), .NOP_BASE(NOP_BASE), .RB_BASE(RB_BASE), .RB_BYTES(RB_BYTES)
  ) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .strobes(strobes), .byteOff(byteOff), .nopIdx(nopIdx), .nBytes(nBytes)
  );

  mtw_datapath #(
    .RB_BYTES(RB_BYTES), .SIGNATURE(SIGNATURE)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteOff(byteOff),
    .nopIdx(nopIdx), .nBytes(nBytes), .wdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/mmio_test_window_chk.sv
module mmio_test_window_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] NOP_BASE  = 16'h0010,
  parameter logic [ADDR_W-1:0] RB_BASE   = 16'h0100,
  parameter int                RB_BYTES  = 64,
  parameter logic [31:0]       SIGNATURE = 32'h5A17_C3E9
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              rspValid,
  input logic [63:0]       rspRdata
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2

  AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2

  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == 64'd0)); // R10

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && (int'(reqAddr) >= int'(RB_BASE) + RB_BYTES))
      |=> (rspRdata == {64{1'b1}})); // R9

  AST_NOP_DWORD_SIG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == NOP_BASE && reqSize == 2'd3)
      |=> (rspRdata == {SIGNATURE, SIGNATURE})); // R7
endmodule

bind mmio_test_window mmio_test_window_chk #(
  .ADDR_W(ADDR_W), .NOP_BASE(NOP_BASE), .RB_BASE(RB_BASE),
  .RB_BYTES(RB_BYTES), .SIGNATURE(SIGNATURE)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid), .rspRdata(rspRdata)
);

// File: tb/tb_mmio_test_window.sv
`timescale 1ns/1ps
module tb_mmio_test_window;
  localparam int          NB  = 'h0010;
  localparam int          RB  = 'h0100;
  localparam logic [31:0] SIG = 32'h5A17_C3E9;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqWrite = 0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic        rspValid;
  logic [63:0] rspRdata;

  int vectors = 0;
  int misses  = 0;
  logic [7:0] refMem [64];

  always #2 clk = ~clk;

  mmio_test_window dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  function automatic string classify(input bit wr, input int addr, input int size);
    int n = 1 << size;
    if (wr) return "R10";
    if (addr >= NB && addr < NB + 8) return (addr == NB) ? "R7" : "R8";
    if (addr >= RB && addr - RB + n <= 64) return "R3";
    if (addr >= RB && addr < RB + 64) return "R5";
    return "R9";
  endfunction

  function automatic logic [63:0] model(input bit wr, input int addr, input int size,
                                        input logic [63:0] wd);
    int n = 1 << size;
    logic [63:0] r = '0;
    logic [63:0] rep = {SIG, SIG};
    if (wr) begin
      if (addr >= RB && addr - RB + n <= 64)
        for (int i = 0; i < n; i++) refMem[addr - RB + i] = wd[8*i +: 8];
      return '0;
    end
    if (addr >= NB && addr < NB + 8) begin
      for (int i = 0; i < n; i++) begin
        int p = addr - NB + i;
        r[8*i +: 8] = (p < 8) ? rep[8*p +: 8] : 8'hFF;
      end
      return r;
    end
    if (addr >= RB && addr - RB + n <= 64) begin
      for (int i = 0; i < n; i++) r[8*i +: 8] = refMem[addr - RB + i];
      return r;
    end
    return {64{1'b1}};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input int size,
                        input logic [63:0] wd, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = 16'(addr); reqSize = 2'(size); reqWdata = wd;
    exp = model(wr, addr, size, wd);
    @(negedge clk);
    reqValid = 0;
    check("R2 rspValid", {63'd0, rspValid}, 64'd1);
    check(tag, rspRdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset rspValid", {63'd0, rspValid}, 64'd0);
    for (int i = 0; i < 8; i++) access(0, RB + 8*i, 3, '0, "R1 scratch zero");

    // R7: offset 0 at every size
    for (int s = 0; s < 4; s++) access(0, NB, s, '0, "R7");
    // R8: odd offsets with 0xFF padding
    access(0, NB + 3, 3, '0, "R8");
    access(0, NB + 7, 1, '0, "R8");
    access(0, NB + 5, 2, '0, "R8");
    // R3 / R10
    access(1, RB + 8, 3, 64'h8877_6655_4433_2211, "R10");
    access(0, RB + 10, 2, '0, "R3");
    access(0, RB + 15, 0, '0, "R3");
    // R4: narrow write into a filled doubleword
    access(1, RB + 9, 0, 64'hFFFF_FFFF_FFFF_FFAB, "R4 write");
    access(0, RB + 8, 3, '0, "R4");
    // R5: ends exactly at 64, then crossing
    access(1, RB + 56, 3, 64'h0102_0304_0506_0708, "R5 write at end");
    access(1, RB + 62, 2, 64'hDEAD_BEEF_DEAD_BEEF, "R5 crossing write");
    access(0, RB + 56, 3, '0, "R5 end intact");
    access(0, RB + 0, 3, '0, "R5 no wrap");
    access(0, RB + 62, 2, '0, "R5 crossing read");
    access(0, RB + 63, 1, '0, "R5 crossing read");
    // R6: probe writes leave scratch alone
    for (int k = 0; k < 8; k++) access(1, NB + k, 3, 64'hA5A5_A5A5_A5A5_A5A5, "R6 write");
    for (int i = 0; i < 8; i++) access(0, RB + 8*i, 3, '0, "R6 scratch intact");
    // R9: misses
    access(0, NB + 8, 3, '0, "R9");
    access(0, RB + 64, 0, '0, "R9");
    access(0, 'hF000, 2, '0, "R9");
    // R2: idle cycle gives no response
    @(negedge clk);
    check("R2 idle", {63'd0, rspValid}, 64'd0);

    for (int t = 0; t < 600; t++) begin
      int sel = int'($urandom % 4);
      int a;
      int sz = int'($urandom % 4);
      bit wr = bit'($urandom % 2);
      logic [63:0] wd = {$urandom, $urandom};
      if (sel == 0)      a = NB + int'($urandom % 10);
      else if (sel == 3) a = int'($urandom % 65536);
      else               a = RB + int'($urandom % 70);
      access(wr, a, sz, wd, classify(wr, a, sz));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule